// File: doc/BRIEF.md
# System control register bank

This block is a bank of 32-bit control and status words that sits behind a simple word-addressed bus with separate read and write strobes and a ready signal. Ordinary writes are stored and come back on later reads, one cycle after the read strobe. The bus never stalls: ready is held high.

A few words have special behaviour. A write to the power-management command word turns its data into a single-cycle reset-request or shutdown-request pulse to the platform. Three identification words always read back with two fixed status bits forced on, and four words load identification constants when reset is applied. The decoded window is 4 KiB, but only the first 512 words are backed by storage. Any access beyond them is dropped or reads as zero, and it raises a one-cycle error flag.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121 and word 0x43 holds 0x05F40121. Every other implemented word holds zero.
- R2: A write with word index below 512 (word index = byte address / 4) stores its data. A read returns the stored word on `busRdata` in the cycle after the read strobe.
- R3: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word ORed with 0x30000000. The stored word itself is not altered, and no other offset is ORed.
- R4: A write to byte offset 0xF00 with data 1 or 2 produces `resetReq` high for exactly the one cycle after the write.
- R5: A write to byte offset 0xF00 with data 3 produces a one-cycle `shutdownReq`. Any other data produces neither pulse, and the two pulses are never high together.
- R6: A write whose word index is 512 or more changes no stored word.
- R7: A read whose word index is 512 or more returns zero.
- R8: `busError` is high for exactly the cycle after any read or write whose word index is 512 or more, and low after in-range accesses and idle cycles.
- R9: `busReady` is high in every cycle.
- R10: Address bits 1:0 are ignored when decoding.
- R11: When a read and a write to the same word fall in one cycle, the read returns the value held before the write, and the new value is visible on the next read.
- R12: The command word follows the ordinary storage rule. With 512 words it lies beyond the bank, so a command write raises its pulse and the error flag together and stores nothing. A later read of it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (12) | Byte address inside the window |
| busRead | input | 1 | Read strobe |
| busWrite | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| busReady | output | 1 | Always high, no wait states |
| busError | output | 1 | One-cycle flag after an out-of-range access |
| resetReq | output | 1 | One-cycle system reset request |
| shutdownReq | output | 1 | One-cycle shutdown request |

## Verification
Two functions can coincide in one cycle. The command decode fires on a write to 0xF00, and that same write falls outside the storage range, so the pulse and the error flag rise together. A read and a write to the same word can also share a cycle. The bench provokes the first case by writing every command value 0 to 5 and 0xFFFFFFFF to 0xF00. It then checks the pulse, the error flag and a later zero readback in the same sampled cycle. It provokes the second case by asserting both strobes on one word, and expects the old value first and the new value on the next read.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned DATA_W = 32;
  localparam logic [31:0] CMD_BYTE_OFFSET = 32'h0000_0F00;
  localparam logic [31:0] FIXED_STATUS_MASK = 32'h3000_0000;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'd0,
    CMD_RESET    = 2'd1,
    CMD_SHUTDOWN = 2'd2
  } pwrCmd_t;

  typedef struct packed {
    logic wrEn;     // in-range write
    logic rdEn;     // in-range read
    logic rdClr;    // out-of-range read: return zero
    logic orFixed;  // force the fixed status bits on this read
  } bankStrobes_t;

  // identification constants loaded at reset
  function automatic logic [DATA_W-1:0] idResetValue(int unsigned word);
    case (word)
      32'h40:  idResetValue = 32'h05F2_0121;
      32'h41:  idResetValue = 32'h0000_0002;
      32'h42:  idResetValue = 32'h05F3_0121;
      32'h43:  idResetValue = 32'h05F4_0121;
      default: idResetValue = '0;
    endcase
  endfunction

  // words that read back with the fixed status bits forced on
  function automatic logic isFixedWord(int unsigned word);
    isFixedWord = (word == 32'h40) || (word == 32'h42) || (word == 32'h43);
  endfunction

  function automatic pwrCmd_t decodeCmd(logic [DATA_W-1:0] data);
    if (data == 32'd1 || data == 32'd2) decodeCmd = CMD_RESET;
    else if (data == 32'd3)             decodeCmd = CMD_SHUTDOWN;
    else                                decodeCmd = CMD_NONE;
  endfunction

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned WORD_COUNT = 512,
  localparam int unsigned IDX_W     = ADDR_W - 2,
  localparam int unsigned MEM_IDX_W = $clog2(WORD_COUNT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busRead,
  input  logic                 busWrite,
  input  logic [DATA_W-1:0]    busWdata,
  output bankStrobes_t         strobes,
  output logic [MEM_IDX_W-1:0] memIdx,
  output logic                 busError,
  output logic                 resetReq,
  output logic                 shutdownReq
);

  localparam logic [IDX_W:0]   LIMIT   = (IDX_W+1)'(WORD_COUNT);
  localparam logic [IDX_W-1:0] CMD_IDX = IDX_W'(CMD_BYTE_OFFSET >> 2);

  logic [IDX_W-1:0] wordIdx;
  logic             inRange;
  logic             cmdHit;
  logic             lowBitsUnused;
  pwrCmd_t          cmd;

  assign wordIdx       = busAddr[ADDR_W-1:2];
  assign lowBitsUnused = ^busAddr[1:0];
  assign inRange       = {1'b0, wordIdx} < LIMIT;
  assign cmdHit        = busWrite && (wordIdx == CMD_IDX);
  assign cmd           = cmdHit ? decodeCmd(busWdata) : CMD_NONE;
  assign memIdx        = wordIdx[MEM_IDX_W-1:0];

  always_comb begin
    strobes         = '0;
    strobes.wrEn    = busWrite && inRange;
    strobes.rdEn    = busRead && inRange;
    strobes.rdClr   = busRead && !inRange;
    strobes.orFixed = isFixedWord(32'(wordIdx));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busError    <= 1'b0;
      resetReq    <= 1'b0;
      shutdownReq <= 1'b0;
    end else begin
      busError    <= (busRead || busWrite) && !inRange;
      resetReq    <= (cmd == CMD_RESET);
      shutdownReq <= (cmd == CMD_SHUTDOWN);
    end
  end

  // R5: the two power pulses are mutually exclusive
  p_cmd_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(resetReq && shutdownReq));

  // R4: a reset pulse follows a write carrying data 1 or 2
  p_reset_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> ($past(busWrite) &&
                  ($past(busWdata) == 32'd1 || $past(busWdata) == 32'd2)));

  // R5: a shutdown pulse follows a write carrying data 3
  p_shutdown_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> ($past(busWrite) && $past(busWdata) == 32'd3));

  // R8: the error flag only follows an access
  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    busError |-> $past(busRead || busWrite));

endmodule

// File: rtl/sysctl_datapath.sv
module sysctl_datapath
  import sysctl_pkg::*;
#(
  parameter int unsigned WORD_COUNT = 512,
  localparam int unsigned MEM_IDX_W = $clog2(WORD_COUNT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bankStrobes_t         strobes,
  input  logic [MEM_IDX_W-1:0] memIdx,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata
);

  logic [DATA_W-1:0] bankMem [WORD_COUNT];
  logic [DATA_W-1:0] rdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < int'(WORD_COUNT); i++) begin
        bankMem[i] <= idResetValue(32'(i));
      end
    end else if (strobes.wrEn) begin
      bankMem[memIdx] <= busWdata;
    end
  end

  assign rdWord = bankMem[memIdx] | (strobes.orFixed ? FIXED_STATUS_MASK : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (strobes.rdEn) begin
      busRdata <= rdWord;
    end else if (strobes.rdClr) begin
      busRdata <= '0;
    end
  end

  // R7: decode never asks for an in-range and an out-of-range read at once
  p_rd_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.rdEn, strobes.rdClr}));

  // R7: an out-of-range read returns zero
  p_rd_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdClr |=> (busRdata == '0));

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned WORD_COUNT = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busReady,
  output logic              busError,
  output logic              resetReq,
  output logic              shutdownReq
);

  localparam int unsigned MEM_IDX_W = $clog2(WORD_COUNT);

  bankStrobes_t         strobes;
  logic [MEM_IDX_W-1:0] memIdx;

  assign busReady = 1'b1;

  sysctl_ctrl #(
    .ADDR_W    (ADDR_W),
    .WORD_COUNT(WORD_COUNT)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busRead    (busRead),
    .busWrite   (busWrite),
    .busWdata   (busWdata),
    .strobes    (strobes),
    .memIdx     (memIdx),
    .busError   (busError),
    .resetReq   (resetReq),
    .shutdownReq(shutdownReq)
  );

  sysctl_datapath #(
    .WORD_COUNT(WORD_COUNT)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .memIdx  (memIdx),
    .busWdata(busWdata),
    .busRdata(busRdata)
  );

endmodule

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busRead = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busReady;
  logic        busError;
  logic        resetReq;
  logic        shutdownReq;

  int unsigned checks = 0;
  int unsigned fails = 0;
  bit          finished = 1'b0;
  logic [31:0] model [512];

  logic [31:0] obsRdata;
  logic        obsErr, obsRst, obsShd, obsRdy;

  always #5 clk = ~clk;

  sysctl_regbank dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .busWdata(busWdata), .busRdata(busRdata),
    .busReady(busReady), .busError(busError), .resetReq(resetReq),
    .shutdownReq(shutdownReq)
  );

  function automatic logic [31:0] expReset(int w);
    case (w)
      'h40: return 32'h05F20121;
      'h41: return 32'h00000002;
      'h42: return 32'h05F30121;
      'h43: return 32'h05F40121;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] expMask(int w);
    return (w == 'h40 || w == 'h42 || w == 'h43) ? 32'h30000000 : 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, sample at the following negedge
  task automatic access(input logic rd, input logic wr, input logic [11:0] a, input logic [31:0] d);
    busRead = rd; busWrite = wr; busAddr = a; busWdata = d;
    @(negedge clk);
    obsRdata = busRdata; obsErr = busError; obsRst = resetReq;
    obsShd = shutdownReq; obsRdy = busReady;
    busRead = 1'b0; busWrite = 1'b0;
  endtask

  task automatic readAll(input string tag);
    for (int w = 0; w < 512; w++) begin
      access(1'b1, 1'b0, 12'(w * 4), 32'h0);
      check(tag, obsRdata, model[w] | expMask(w));
      check({tag, " err R8"}, 32'(obsErr), 32'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 reset err", 32'(busError), 32'h0);
    check("R4 reset pulse idle", 32'(resetReq), 32'h0);
    check("R5 shutdown idle", 32'(shutdownReq), 32'h0);

    // R1 + R3: reset contents, including ORed identification words
    for (int w = 0; w < 512; w++) model[w] = expReset(w);
    readAll("R1 reset value");

    // R2: arithmetic pattern to every word, then read back (R3 OR still applies)
    for (int w = 0; w < 512; w++) begin
      model[w] = 32'(w) * 32'h9E3779B1 ^ 32'h5A5A0000;
      access(1'b0, 1'b1, 12'(w * 4), model[w]);
      check("R2 write err", 32'(obsErr), 32'h0);
      check("R9 ready", 32'(obsRdy), 32'h1);
    end
    readAll("R2 readback");

    // R3: stored value unchanged by OR; zero stored reads as mask only
    access(1'b0, 1'b1, 12'h100, 32'h0);
    model['h40] = 32'h0;
    access(1'b1, 1'b0, 12'h100, 32'h0);
    check("R3 or-on-read 0x100", obsRdata, 32'h30000000);
    access(1'b0, 1'b1, 12'h104, 32'h0);
    model['h41] = 32'h0;
    access(1'b1, 1'b0, 12'h104, 32'h0);
    check("R3 no OR at 0x104", obsRdata, 32'h0);
    access(1'b0, 1'b1, 12'h10C, 32'hC0000001);
    model['h43] = 32'hC0000001;
    access(1'b1, 1'b0, 12'h10C, 32'h0);
    check("R3 or-on-read 0x10C", obsRdata, 32'hF0000001);

    // R10: low address bits ignored
    access(1'b0, 1'b1, 12'h013, 32'hDEADBEEF);
    model[4] = 32'hDEADBEEF;
    access(1'b1, 1'b0, 12'h010, 32'h0);
    check("R10 low bits write", obsRdata, 32'hDEADBEEF);
    access(1'b1, 1'b0, 12'h10A, 32'h0);
    check("R10 low bits read 0x10A", obsRdata, model['h42] | 32'h30000000);

    // R11: read and write on the same word in one cycle
    access(1'b1, 1'b1, 12'h014, 32'h12345678);
    check("R11 old value", obsRdata, model[5]);
    model[5] = 32'h12345678;
    access(1'b1, 1'b0, 12'h014, 32'h0);
    check("R11 new value", obsRdata, 32'h12345678);

    // R6, R7, R8: out-of-range reads and writes
    for (int k = 0; k < 8; k++) begin
      logic [11:0] a;
      a = 12'h800 + 12'(k * 12'h0FC);
      access(1'b0, 1'b1, a, 32'hFFFF0000 | 32'(k));
      check("R8 err after oob write", 32'(obsErr), 32'h1);
      check("R4 no pulse oob write", 32'(obsRst | obsShd), 32'h0);
      access(1'b1, 1'b0, a, 32'h0);
      check("R7 oob read zero", obsRdata, 32'h0);
      check("R8 err after oob read", 32'(obsErr), 32'h1);
      access(1'b0, 1'b0, 12'h0, 32'h0);
      check("R8 err single cycle", 32'(obsErr), 32'h0);
    end
    access(1'b0, 1'b1, 12'hFFC, 32'hAAAAAAAA);
    check("R8 err top word", 32'(obsErr), 32'h1);
    readAll("R6 unchanged after oob writes");

    // R4, R5, R12: every command value at 0xF00
    for (int c = 0; c < 7; c++) begin
      logic [31:0] d;
      d = (c == 6) ? 32'hFFFFFFFF : 32'(c);
      access(1'b0, 1'b1, 12'hF00, d);
      check("R4 reset pulse", 32'(obsRst), 32'((d == 1) || (d == 2)));
      check("R5 shutdown pulse", 32'(obsShd), 32'(d == 3));
      check("R12 err with command", 32'(obsErr), 32'h1);
      access(1'b0, 1'b0, 12'h0, 32'h0);
      check("R4 pulse one cycle", 32'(obsRst), 32'h0);
      check("R5 pulse one cycle", 32'(obsShd), 32'h0);
      access(1'b1, 1'b0, 12'hF00, 32'h0);
      check("R12 command word reads zero", obsRdata, 32'h0);
    end
    // R10 on the command word
    access(1'b0, 1'b1, 12'hF03, 32'h3);
    check("R10 command low bits", 32'(obsShd), 32'h1);
    readAll("R12 bank unchanged by commands");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule